// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Generator

This block connects a processor-side access port to a system bus whose devices may be 8, 16 or 32 bits wide. The processor side presents one request carrying an address, a size (byte, word or longword), a direction and right-justified write data. It then waits for a single completion. On the system side the block runs bus cycles. Each cycle ends when the responding device returns a two-line, active-low port-width acknowledge. From that acknowledge the block learns at run time how many bytes the cycle moved. It then starts further cycles at the following address until the whole access is done, so one request can turn into as many as four system-bus cycles.

For writes, the block drives the bytes not yet sent onto every lane position that a port of any width could be looking at. For reads, it picks the returned bytes off the lanes that the acknowledged width implies and merges them into an accumulator. When the last cycle is acknowledged, it raises a one-cycle completion pulse. The fully assembled read word is valid in that same cycle. Misaligned accesses are split on port boundaries in the same way.

Top module: `bus_sizer`

## Requirements
- R1: While `req_ready` is high, a `req_valid` sample starts an access. From the next cycle `bus_strobe` is high, `req_ready` is low, `bus_addr` equals the request address and `bus_write` equals the request direction.
- R2: Each access produces exactly one `done` pulse, one cycle long. It appears in the cycle after the final acknowledged bus cycle, and `bus_strobe` is low in that cycle.
- R3: `bus_ack_n` encodes the port width: 01 = 8-bit, 10 = 16-bit, 00 = 32-bit, 11 = wait. During a wait the bus address, remaining count and write data stay unchanged.
- R4: Each acknowledged cycle moves n = min(remaining, P − (address mod P)) bytes, where P is the port width in bytes. The next cycle's `bus_addr` is the old address plus n, and `bus_rem` is the old remaining count minus n. `bus_rem` starts at the access size in bytes: `req_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R5: A longword access to an 8-bit port takes four bus cycles at four consecutive addresses.
- R6: A byte access completes in one bus cycle at every port width and every address offset.
- R7: An access that crosses a 32-bit boundary is split even on a 32-bit port. A longword at offset 2 takes two cycles, and one at offset 3 takes a 1-byte cycle followed by a 3-byte cycle.
- R8: Write lanes are big-endian. Lane 0 is bits 31..24 and lane 3 is bits 7..0. A 32-bit port takes the next unsent byte on lane (address mod 4), a 16-bit port on lane (address mod 2), and an 8-bit port on lane 0. Later bytes go on the following lanes.
- R9: Read bytes are taken from the same lanes as in R8. In the `done` cycle, `rdata` holds the access right-justified, with the byte from the lowest address most significant.
- R10: A `req_valid` presented while an access is in progress is ignored. The bus address does not change, and no extra bus cycle follows the completion.
- R11: After reset, `req_ready` is high and `bus_strobe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the processor side |
| req_ready | output | 1 | High when a new request can be taken |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Right-justified assembled read data, valid with done |
| bus_strobe | output | 1 | A system-bus cycle is in progress |
| bus_addr | output | AW | Address of the current bus cycle |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_rem | output | 3 | Bytes still to move, 1 to 4 |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_rdata | input | 32 | Read data from the responding port |
| bus_ack_n | input | 2 | Active-low port-width acknowledge |

## Verification
Accesses of every size are run against 8-, 16- and 32-bit ports at aligned and odd addresses. This separates a split driven by port width from a split driven by alignment (for example, a longword at offset 1 on a 16-bit port becomes 1+2+1 bytes). The bench model fills the lanes a port does not use with a fixed pad byte, so a gather that reads the wrong lane shows up in `rdata`. The bench reads writes back from the per-width lanes, which exposes errors in the replicated lane placement. Wait states inserted between acknowledges, and a request pulse during a busy access, show that nothing advances without a valid acknowledge.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;

  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  localparam logic [1:0] ACK_P8   = 2'b01;
  localparam logic [1:0] ACK_P16  = 2'b10;
  localparam logic [1:0] ACK_P32  = 2'b00;
  localparam logic [1:0] ACK_WAIT = 2'b11;

  // access size in bytes; code 3 is treated as a longword
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // port width in bytes from the acknowledge, 0 while waiting
  function automatic logic [2:0] port_bytes(input logic [1:0] ack_n);
    case (ack_n)
      ACK_P8:  return 3'd1;
      ACK_P16: return 3'd2;
      ACK_P32: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // bytes moved in one beat: limited by what remains and by the port boundary
  function automatic logic [2:0] beat_bytes(input logic [2:0] rem, input logic [2:0] pb,
                                            input logic [1:0] lo);
    logic [1:0] mask;
    logic [2:0] room;
    mask = pb[1:0] - 2'd1;
    room = pb - {1'b0, lo & mask};
    return (rem < room) ? rem : room;
  endfunction

  // place left-justified unsent bytes so that 8-, 16- and 32-bit ports all see them
  function automatic logic [DW-1:0] lane_fill(input logic [DW-1:0] pend, input logic [1:0] lo);
    logic [DW-1:0] out;
    int idx;
    out = '0;
    for (int l = 0; l < LANES; l++) begin
      if (l >= int'(lo))            idx = l - int'(lo);
      else if (l >= int'(lo[0]))    idx = l - int'(lo[0]);
      else                          idx = 0;
      out[DW-1-8*l -: 8] = pend[DW-1-8*idx -: 8];
    end
    return out;
  endfunction

  // shift the accumulator up by n bytes and append the n bytes the port returned
  function automatic logic [DW-1:0] gather(input logic [DW-1:0] acc, input logic [DW-1:0] rd,
                                           input logic [2:0] pb, input logic [1:0] lo,
                                           input logic [2:0] n);
    logic [1:0]      off;
    logic [DW-1:0]   got;
    logic [2*DW-1:0] both;
    off  = lo & (pb[1:0] - 2'd1);
    got  = rd << (8 * int'(off));
    both = {acc, got} << (8 * int'(n));
    return both[2*DW-1:DW];
  endfunction

endpackage

// File: rtl/bsz_seq.sv
module bsz_seq
  import bus_sizer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [1:0]    bus_ack_n,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic [2:0]    rem,
  output logic          wr,
  output logic          start,
  output logic          ack_taken,
  output logic [2:0]    pb,
  output logic [2:0]    xfer,
  output logic          last_beat,
  output logic          done
);

  always_comb begin
    start     = req_valid && !busy;
    pb        = port_bytes(bus_ack_n);
    ack_taken = busy && (pb != 3'd0);
    xfer      = beat_bytes(rem, pb, addr[1:0]);
    last_beat = ack_taken && (xfer == rem);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
      rem  <= '0;
      wr   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_beat;
      if (start) begin
        busy <= 1'b1;
        addr <= req_addr;
        rem  <= size_bytes(req_size);
        wr   <= req_write;
      end else if (ack_taken) begin
        addr <= addr + AW'(xfer);
        rem  <= rem - xfer;
        if (last_beat) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bsz_wlane.sv
module bsz_wlane
  import bus_sizer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  input  logic          ack_taken,
  input  logic [2:0]    xfer,
  input  logic [1:0]    addr_lo,
  output logic [DW-1:0] bus_wdata
);

  logic [DW-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (start) begin
      pend <= req_wdata << (8 * (LANES - int'(size_bytes(req_size))));
    end else if (ack_taken) begin
      pend <= pend << (8 * int'(xfer));
    end
  end

  assign bus_wdata = lane_fill(pend, addr_lo);

endmodule

// File: rtl/bsz_rgather.sv
module bsz_rgather
  import bus_sizer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack_taken,
  input  logic          last_beat,
  input  logic [2:0]    pb,
  input  logic [2:0]    xfer,
  input  logic [1:0]    addr_lo,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] acc;
  logic [DW-1:0] merged;

  assign merged = gather(acc, bus_rdata, pb, addr_lo, xfer);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      rdata <= '0;
    end else if (start) begin
      acc <= '0;
    end else if (ack_taken) begin
      acc <= merged;
      if (last_beat) rdata <= merged;
    end
  end

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_strobe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [2:0]    bus_rem,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic [1:0]    bus_ack_n
);

  logic       busy;
  logic       start;
  logic       ack_taken;
  logic       last_beat;
  logic [2:0] pb;
  logic [2:0] xfer;

  bsz_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .bus_ack_n(bus_ack_n),
    .busy(busy), .addr(bus_addr), .rem(bus_rem), .wr(bus_write), .start(start),
    .ack_taken(ack_taken), .pb(pb), .xfer(xfer), .last_beat(last_beat), .done(done)
  );

  bsz_wlane wlane_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_size(req_size), .req_wdata(req_wdata),
    .ack_taken(ack_taken), .xfer(xfer), .addr_lo(bus_addr[1:0]), .bus_wdata(bus_wdata)
  );

  bsz_rgather rgather_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ack_taken(ack_taken), .last_beat(last_beat),
    .pb(pb), .xfer(xfer), .addr_lo(bus_addr[1:0]), .bus_rdata(bus_rdata), .rdata(rdata)
  );

  assign req_ready  = !busy;
  assign bus_strobe = busy;

endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          done,
  input logic          bus_strobe,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_rem,
  input logic [31:0]   bus_wdata,
  input logic [1:0]    bus_ack_n,
  input logic          ack_taken,
  input logic          last_beat,
  input logic [2:0]    xfer
);

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_strobe && !req_ready && bus_addr == $past(req_addr));

  // R2
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done && !bus_strobe);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && bus_ack_n == 2'b11 |=>
      bus_strobe && $stable(bus_addr) && $stable(bus_rem) && $stable(bus_wdata));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken && !last_beat |=>
      bus_addr == $past(bus_addr) + AW'($past(xfer)) && bus_rem == $past(bus_rem) - $past(xfer));

  // R4
  xfer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken |-> xfer != 3'd0 && xfer <= bus_rem);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && req_valid && !ack_taken |=> $stable(bus_addr));

endmodule

bind bus_sizer bus_sizer_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .done(done), .bus_strobe(bus_strobe), .bus_addr(bus_addr), .bus_rem(bus_rem),
  .bus_wdata(bus_wdata), .bus_ack_n(bus_ack_n), .ack_taken(ack_taken),
  .last_beat(last_beat), .xfer(xfer)
);

// File: tb/bus_sizer_tb_top.sv
`timescale 1ns/1ps
module bus_sizer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        done;
  logic [31:0] rdata;
  logic        bus_strobe;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [2:0]  bus_rem;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_ack_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_sizer #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_rem(bus_rem), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return 8'((a * 37) + 11);
  endfunction

  function automatic logic [1:0] ack_code(input int pb);
    if (pb == 1) return 2'b01;
    if (pb == 2) return 2'b10;
    return 2'b00;
  endfunction

  // one access against a port of pb bytes; waits inserted before each acknowledge
  task automatic run_access(input string req, input logic [31:0] a, input logic [1:0] sz,
                            input logic wr, input logic [31:0] wd, input int pb,
                            input int waits, input int exp_beats, input bit poke);
    int          nbytes;
    int          rem;
    int          beats;
    int          n;
    int          room;
    logic [31:0] cur;
    logic [31:0] base;
    logic [31:0] exp_rd;
    logic [31:0] got_wr;
    nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    exp_rd = '0;
    for (int i = 0; i < nbytes; i++) exp_rd = (exp_rd << 8) | 32'(mem_byte(a + 32'(i)));
    got_wr = '0;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // R1: bus cycle starts with the request address and direction
    chk("R1", "bus_write", 32'(bus_write), 32'(wr));
    chk("R1", "req_ready", 32'(req_ready), 32'd0);
    cur = a; rem = nbytes; beats = 0;
    while (rem > 0 && beats < 8) begin
      chk("R4", "bus_strobe", 32'(bus_strobe), 32'd1);
      chk("R4", "bus_addr", bus_addr, cur);
      chk("R4", "bus_rem", 32'(bus_rem), 32'(rem));
      chk("R2", "early done", 32'(done), 32'd0);
      for (int w = 0; w < waits; w++) begin
        bus_ack_n = 2'b11;
        if (poke && w == 0) begin
          req_valid = 1'b1; req_addr = 32'hFFFF_0000;
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R3 wait holds the cycle; R10 poke ignored
        chk(poke ? "R10" : "R3", "addr in wait", bus_addr, cur);
        chk("R3", "rem in wait", 32'(bus_rem), 32'(rem));
      end
      room = pb - int'(cur % 32'(pb));
      n = (rem < room) ? rem : room;
      base = (pb == 4) ? (cur & ~32'd3) : (pb == 2) ? (cur & ~32'd1) : cur;
      bus_rdata = 32'hEEEE_EEEE;
      for (int l = 0; l < pb; l++) bus_rdata[31-8*l -: 8] = mem_byte(base + 32'(l));
      for (int i = 0; i < n; i++) begin
        int lane;
        lane = int'(cur - base) + i;
        got_wr = (got_wr << 8) | 32'(bus_wdata[31-8*lane -: 8]);
      end
      bus_ack_n = ack_code(pb);
      @(negedge clk);
      bus_ack_n = 2'b11;
      bus_rdata = 32'hEEEE_EEEE;
      cur = cur + 32'(n); rem = rem - n; beats++;
    end
    chk(req, "beat count", 32'(beats), 32'(exp_beats));
    chk("R2", "done", 32'(done), 32'd1);
    chk("R2", "strobe at done", 32'(bus_strobe), 32'd0);
    if (wr) begin
      logic [31:0] exp_wr;
      exp_wr = (nbytes == 4) ? wd : (nbytes == 2) ? {16'd0, wd[15:0]} : {24'd0, wd[7:0]};
      chk("R8", "write lanes", got_wr, exp_wr);
    end else begin
      chk("R9", "rdata", rdata, exp_rd);
    end
    @(negedge clk);
    chk("R2", "done pulse", 32'(done), 32'd0);
    chk("R10", "no extra cycle", 32'(bus_strobe), 32'd0);
  endtask

  task automatic t_reset();
    // R11
    chk("R11", "req_ready", 32'(req_ready), 32'd1);
    chk("R11", "bus_strobe", 32'(bus_strobe), 32'd0);
    chk("R11", "done", 32'(done), 32'd0);
  endtask

  task automatic t_aligned();
    run_access("R4", 32'h100, 2'd2, 1'b0, 32'h0, 4, 0, 1, 0);
    run_access("R4", 32'h202, 2'd1, 1'b1, 32'h0000_A1B2, 2, 0, 1, 0);
  endtask

  task automatic t_narrow();
    // R5 longword to 8-bit port
    run_access("R5", 32'h300, 2'd2, 1'b0, 32'h0, 1, 0, 4, 0);
    run_access("R5", 32'h304, 2'd2, 1'b1, 32'hC0DE_F00D, 1, 0, 4, 0);
    run_access("R4", 32'h308, 2'd2, 1'b0, 32'h0, 2, 0, 2, 0);
  endtask

  task automatic t_misaligned();
    // R7 crossing a 32-bit boundary
    run_access("R7", 32'h402, 2'd2, 1'b0, 32'h0, 4, 0, 2, 0);
    run_access("R7", 32'h413, 2'd2, 1'b1, 32'h1234_5678, 4, 0, 2, 0);
    run_access("R7", 32'h421, 2'd2, 1'b1, 32'h9ABC_DEF0, 2, 0, 3, 0);
    run_access("R7", 32'h433, 2'd1, 1'b0, 32'h0, 4, 0, 2, 0);
  endtask

  task automatic t_bytes();
    // R6 byte access, one cycle everywhere
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 4; o++) begin
        run_access("R6", 32'h500 + 32'(o), 2'd0, 1'(o % 2), 32'h0000_005A + 32'(o), 1 << p, 0, 1, 0);
      end
    end
  endtask

  task automatic t_waits();
    // R3 wait states between acknowledges
    run_access("R3", 32'h601, 2'd2, 1'b0, 32'h0, 2, 2, 3, 0);
  endtask

  task automatic t_busy_poke();
    // R10 request during a busy access
    run_access("R10", 32'h700, 2'd2, 1'b0, 32'h0, 1, 1, 4, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; bus_rdata = 32'hEEEE_EEEE; bus_ack_n = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_narrow();
    t_misaligned();
    t_bytes();
    t_waits();
    t_busy_poke();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule